// File: doc/BRIEF.md
# LPC Host Write-Cycle Generator

This block is the host end of a Low Pin Count bus that issues single-byte write cycles in two formats. A standard memory write carries a 32-bit address. A TPM-style write carries a 16-bit address: a 4-bit locality in the top nibble above a 12-bit register offset. The caller presents the cycle kind, address, locality and data on a valid/ready request port. The block serializes the cycle onto the frame strobe and the four shared address/data lines, releases the lines for turnaround, and watches for the target's SYNC handshake.

Each cycle ends in one of two ways. A one-clock `done_o` pulse marks a completed cycle. A one-clock `timeout_o` pulse marks a cycle in which no ready SYNC arrived within `sync_limit_i` sampled clocks. The block accepts a new request in the same clock in which either pulse is high.

Top module: `lpc_wr_host`

## Requirements
- R1: While idle, and right after reset, `lframe_no` is 1 and the host drives 4'hF on `lad_o` with `lad_oe_o` high. `req_ready_o` is 1, and `done_o` and `timeout_o` are 0.
- R2: In the clock after a request is accepted, `lframe_no` is 0 for exactly that one clock. `lad_o` carries START, which is 4'h0 for a memory write and 4'h5 for a TPM write (`req_tpm_i`=1).
- R3: The next clock carries the type/direction nibble: 4'h6 for a memory write and 4'h2 for a TPM write.
- R4: A memory write then sends `req_addr_i` as eight nibbles, one per clock, starting with bits [31:28].
- R5: A TPM write instead sends four address nibbles in this order: `req_loc_i`, then `req_addr_i`[11:8], [7:4] and [3:0].
- R6: The data byte follows over two clocks, bits [3:0] first and then bits [7:4].
- R7: Turnaround follows. On its first clock the host drives 4'hF. On its second clock `lad_oe_o` is 0, and it stays 0 for every SYNC clock.
- R8: During SYNC the host samples `lad_i` once per clock. A value of 4'h0 ends the wait. The values 4'h5 and 4'h6, and any other value, keep the host waiting.
- R9: If `sync_limit_i` samples pass with none equal to 4'h0, the host returns to idle and `timeout_o` is high for the first idle clock, with `done_o` low. A 4'h0 on the last allowed sample still counts as success.
- R10: After a ready SYNC the host drives 4'hF for two clocks. It then returns to idle with `done_o` high for the first idle clock only.
- R11: From acceptance to the end of the cycle `req_ready_o` is 0. Any `req_valid_i` or request field changes during that time do not alter the cycle on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Host idle; request taken when valid is also high |
| req_tpm_i | input | 1 | 1 selects TPM-style write, 0 memory write |
| req_addr_i | input | 32 | Memory address, or register offset in bits [11:0] |
| req_loc_i | input | 4 | Locality for TPM-style writes |
| req_data_i | input | 8 | Data byte |
| sync_limit_i | input | TMO_W | Maximum SYNC clocks sampled before timeout (at least 1) |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | Address/data lines, host value |
| lad_oe_o | output | 1 | Host drives address/data lines when 1 |
| lad_i | input | 4 | Address/data lines as seen from the bus |
| done_o | output | 1 | One-clock pulse: cycle completed |
| timeout_o | output | 1 | One-clock pulse: SYNC wait expired |

## Verification
The bench builds the block with `TMO_W` set to 4, so the limit port is narrow and its boundary values are cheap to reach. The runs use a limit of 12 for the ordinary traffic and a limit of 3 for the timeout cases. With a limit of 3, the bench can exhaust the wait within a few clocks. It also reaches the edge case where a ready SYNC lands on exactly the last permitted sample. The ordinary runs mix short-wait, long-wait and invalid SYNC nibbles before the ready code, and they include a cycle during which the request port is driven with unrelated values while the host is busy.

// File: rtl/lpc_wr_pkg.sv
package lpc_wr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTDIR, ST_ADDR, ST_DATA,
    ST_TAR_DRV, ST_TAR_REL, ST_SYNC, ST_RTAR0, ST_RTAR1
  } state_e;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MEM_NIBS = ADDR_W / 4;
  localparam int unsigned TPM_NIBS = 4;
  localparam int unsigned CNT_W    = $clog2(MEM_NIBS);

  localparam logic [3:0] START_MEM  = 4'h0;
  localparam logic [3:0] START_TPM  = 4'h5;
  localparam logic [3:0] CT_MEM_WR  = 4'h6;
  localparam logic [3:0] CT_TPM_WR  = 4'h2;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] NIB_PARK   = 4'hF;
endpackage

// File: rtl/lpc_wr_nib_mux.sv
module lpc_wr_nib_mux
  import lpc_wr_pkg::*;
(
  input  state_e                  state_i,
  input  logic                    tpm_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [3:0]              nib_o
);
  localparam int unsigned DNIBS = DATA_W / 4;

  logic [3:0] addr_nib [MEM_NIBS];
  logic [3:0] data_nib [DNIBS];

  for (genvar g = 0; g < MEM_NIBS; g++) begin : g_anib
    assign addr_nib[g] = addr_i[4*g +: 4];
  end
  for (genvar g = 0; g < DNIBS; g++) begin : g_dnib
    assign data_nib[g] = data_i[4*g +: 4];
  end

  always_comb begin
    unique case (state_i)
      ST_START: nib_o = tpm_i ? START_TPM : START_MEM;
      ST_CTDIR: nib_o = tpm_i ? CT_TPM_WR : CT_MEM_WR;
      ST_ADDR:  nib_o = addr_nib[cnt_i];
      ST_DATA:  nib_o = data_nib[cnt_i[0]];
      default:  nib_o = NIB_PARK;
    endcase
  end
endmodule

// File: rtl/lpc_wr_sync_mon.sv
module lpc_wr_sync_mon #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [3:0]       lad_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             ready_o,
  output logic             expire_o
);
  logic [TMO_W-1:0] wait_q;
  logic [TMO_W-1:0] lim_m1;

  assign lim_m1   = limit_i - {{(TMO_W-1){1'b0}}, 1'b1};
  assign ready_o  = active_i && (lad_i == lpc_wr_pkg::SYNC_READY);
  assign expire_o = active_i && !ready_o && (wait_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wait_q <= '0;
    else if (!active_i) wait_q <= '0;
    else                wait_q <= wait_q + 1'b1;
  end
endmodule

// File: rtl/lpc_wr_host.sv
module lpc_wr_host
  import lpc_wr_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_tpm_i,
  input  logic [31:0]       req_addr_i,
  input  logic [3:0]        req_loc_i,
  input  logic [7:0]        req_data_i,
  input  logic [TMO_W-1:0]  sync_limit_i,
  output logic              lframe_no,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [3:0]        lad_i,
  output logic              done_o,
  output logic              timeout_o
);
  state_e             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tpm_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               done_q, tmo_q;
  logic               sync_ok, sync_exp;

  lpc_wr_sync_mon #(.TMO_W(TMO_W)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_SYNC),
    .lad_i    (lad_i),
    .limit_i  (sync_limit_i),
    .ready_o  (sync_ok),
    .expire_o (sync_exp)
  );

  lpc_wr_nib_mux u_mux (
    .state_i (state_q),
    .tpm_i   (tpm_q),
    .addr_i  (addr_q),
    .data_i  (data_q),
    .cnt_i   (cnt_q),
    .nib_o   (lad_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tpm_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          tpm_q   <= req_tpm_i;
          // TPM short address: locality above 12-bit offset
          addr_q  <= req_tpm_i ? {16'h0, req_loc_i, req_addr_i[11:0]} : req_addr_i;
          data_q  <= req_data_i;
          state_q <= ST_START;
        end
        ST_START: state_q <= ST_CTDIR;
        ST_CTDIR: begin
          cnt_q   <= tpm_q ? CNT_W'(TPM_NIBS - 1) : CNT_W'(MEM_NIBS - 1);
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (cnt_q == '0) state_q <= ST_DATA;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DATA: begin
          if (cnt_q[0]) begin
            cnt_q   <= '0;
            state_q <= ST_TAR_DRV;
          end else cnt_q <= CNT_W'(1);
        end
        ST_TAR_DRV: state_q <= ST_TAR_REL;
        ST_TAR_REL: state_q <= ST_SYNC;
        ST_SYNC: begin
          if (sync_ok) state_q <= ST_RTAR0;
          else if (sync_exp) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RTAR0: state_q <= ST_RTAR1;
        ST_RTAR1: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign lframe_no   = (state_q != ST_START);
  assign lad_oe_o    = !((state_q == ST_TAR_REL) || (state_q == ST_SYNC));
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
endmodule

// File: rtl/lpc_wr_host_chk.sv
module lpc_wr_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       lframe_no,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       done_o,
  input logic       timeout_o
);
  p_idle_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (lframe_no && lad_oe_o && lad_o == 4'hF));

  p_start_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |-> (lad_oe_o && (lad_o == 4'h0 || lad_o == 4'h5)));

  p_frame_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |=> lframe_no);

  p_tmo_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!$past(lad_oe_o) && !done_o));

  p_done_after_tar_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(lad_oe_o) && $past(lad_o) == 4'hF && req_ready_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> (!req_ready_o && !lframe_no));
endmodule

bind lpc_wr_host lpc_wr_host_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .lframe_no   (lframe_no),
  .lad_o       (lad_o),
  .lad_oe_o    (lad_oe_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/lpc_wr_host_tb.sv
`timescale 1ns/1ps
module lpc_wr_host_tb;
  localparam int unsigned TMO_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_tpm = 1'b0;
  logic [31:0]      req_addr = '0;
  logic [3:0]       req_loc = '0;
  logic [7:0]       req_data = '0;
  logic [TMO_W-1:0] limit = 4'd12;
  logic             lframe_n;
  logic [3:0]       lad_o;
  logic             lad_oe;
  logic [3:0]       lad_i = 4'hF;
  logic             done, tmo;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic       frame, oe;
    logic [3:0] lad, rsp;
    logic       rdy, done, tmo;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  lpc_wr_host #(.TMO_W(TMO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_tpm_i(req_tpm), .req_addr_i(req_addr), .req_loc_i(req_loc), .req_data_i(req_data),
    .sync_limit_i(limit), .lframe_no(lframe_n), .lad_o(lad_o), .lad_oe_o(lad_oe),
    .lad_i(lad_i), .done_o(done), .timeout_o(tmo)
  );

  function automatic void push(logic f, logic oe, logic [3:0] l, logic [3:0] r,
                               logic rd, logic dn, logic tm, string t);
    exp_t e;
    e.frame = f; e.oe = oe; e.lad = l; e.rsp = r; e.rdy = rd; e.done = dn; e.tmo = tm;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  // Monitor: one expected item per clock, sampled mid-cycle; also plays the target's SYNC
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      logic  bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      bad = (lframe_n !== e.frame) || (lad_oe !== e.oe) || (req_ready !== e.rdy) ||
            (done !== e.done) || (tmo !== e.tmo) || (e.oe && lad_o !== e.lad);
      if (bad) begin
        fails++;
        $display("FAIL %s: got frame=%b oe=%b lad=%h rdy=%b done=%b tmo=%b exp frame=%b oe=%b lad=%h rdy=%b done=%b tmo=%b",
                 t, lframe_n, lad_oe, lad_o, req_ready, done, tmo,
                 e.frame, e.oe, e.lad, e.rdy, e.done, e.tmo);
      end
      lad_i = e.rsp;
    end
  end

  task automatic issue(bit tpm, logic [31:0] a, logic [3:0] l, logic [7:0] d,
                       int nwait, logic [3:0] wc, bit ok, bit noise);
    logic [31:0] word;
    int          n;
    @(negedge clk);
    req_tpm = tpm; req_addr = a; req_loc = l; req_data = d; req_valid = 1'b1;
    @(posedge clk); #1;
    push(1'b0, 1'b1, tpm ? 4'h5 : 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, "R2");
    push(1'b1, 1'b1, tpm ? 4'h2 : 4'h6, 4'hF, 1'b0, 1'b0, 1'b0, "R3");
    n    = tpm ? 4 : 8;
    word = tpm ? {16'h0, l, a[11:0]} : a;
    for (int i = n - 1; i >= 0; i--)
      push(1'b1, 1'b1, word[4*i +: 4], 4'hF, 1'b0, 1'b0, 1'b0, tpm ? "R5" : "R4");
    push(1'b1, 1'b1, d[3:0], 4'hF, 1'b0, 1'b0, 1'b0, "R6");
    push(1'b1, 1'b1, d[7:4], 4'hF, 1'b0, 1'b0, 1'b0, "R6");
    push(1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, "R7");
    push(1'b1, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < nwait; i++)
      push(1'b1, 1'b0, 4'hF, (i % 2 == 1) ? 4'h6 : wc, 1'b0, 1'b0, 1'b0, "R8");
    if (ok) begin
      push(1'b1, 1'b0, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0, "R8");
      push(1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, "R10");
      push(1'b1, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0, "R10");
      push(1'b1, 1'b1, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, "R10");
    end else begin
      push(1'b1, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1, "R9");
    end
    if (noise) begin
      // R11: request port churns while busy; bus sequence must not change
      req_tpm = ~tpm; req_addr = ~a; req_loc = ~l; req_data = ~d;
      repeat (3) @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        checks++;  // R1 reset/idle state
        if (lframe_n !== 1'b1 || lad_oe !== 1'b1 || lad_o !== 4'hF ||
            req_ready !== 1'b1 || done !== 1'b0 || tmo !== 1'b0) begin
          fails++;
          $display("FAIL R1: got frame=%b oe=%b lad=%h rdy=%b done=%b tmo=%b exp 1 1 f 1 0 0",
                   lframe_n, lad_oe, lad_o, req_ready, done, tmo);
        end
        limit = 4'd12;
        issue(1'b0, 32'h1234_5678, 4'h0, 8'hA5, 0, 4'h5, 1'b1, 1'b0);
        issue(1'b1, 32'hFFFF_F020, 4'h4, 8'h3C, 3, 4'h5, 1'b1, 1'b0);
        issue(1'b0, 32'h8000_00C1, 4'h0, 8'h5E, 2, 4'h9, 1'b1, 1'b1);
        issue(1'b1, 32'h0000_0FFF, 4'h0, 8'hFF, 0, 4'h5, 1'b1, 1'b0);
        limit = 4'd3;
        issue(1'b0, 32'hDEAD_BEEF, 4'h0, 8'h01, 3, 4'h6, 1'b0, 1'b0);  // R9 expire
        issue(1'b1, 32'h0000_0ABC, 4'hB, 8'h80, 2, 4'h5, 1'b1, 1'b0);  // R9 last-sample ready
        issue(1'b1, 32'h0000_0123, 4'h2, 8'h7E, 3, 4'h5, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got hung run exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule